// File: doc/BRIEF.md
# Temperature Monitor Two-Wire Register Target

This block is the two-wire (I2C) target front end of a temperature monitor. It keeps five registers behind one pointer. The temperature word is read-only and comes in from the converter on `temp_in`. The configuration byte and the low, high and critical limit words can be written and read. A host write always carries the pointer byte after the address byte. The pointer stays latched after the transfer, so a later read can skip the pointer byte and return the register that was last pointed to.

Reads return the most significant byte first, and each byte most significant bit first. A read goes on for as long as the host acknowledges and ends when the host sends a NACK. The target drives the data line only through an open-drain enable, `sda_oe`. A one-cycle strobe marks each accepted read, and the interrupt logic around the block uses it to clear its output.

The target never stretches SCL, so the host alone sets the pace. No input or output here exerts back-pressure: `temp_in` is sampled without a handshake whenever a read is accepted, and the register outputs are plain levels that are always valid.

Top module: `tsense_i2c_target`

## Requirements
- R1: After reset the pointer selects the temperature register, the configuration byte is 0x00, each limit holds its reset parameter, `sda_oe` is low and `rd_strobe` is low.
- R2: Only an address byte whose upper seven bits equal `DEV_ADDR` is acknowledged. Any other address gets no ACK, and the rest of that transfer changes no register and not the pointer, until the next start.
- R3: The low three bits of the pointer byte are latched, with codes 0 temperature, 1 configuration, 2 low limit, 3 high limit, 4 critical limit. Codes 5 to 7 read as 0x00 and drop written data. A read that carries no pointer byte uses the latched code.
- R4: A configuration write stores the first data byte. Later data bytes in the same transfer are acknowledged and dropped.
- R5: A limit write takes two data bytes, high byte first, and both halves update in the same clock once the second byte is complete. A transfer that carries only one data byte leaves the limit unchanged. A third or later byte is acknowledged and dropped.
- R6: Data written with pointer code 0 changes no register.
- R7: Read bytes leave most significant bit first. A 16-bit register alternates between its high and low byte, starting with the high byte. The configuration register repeats its single byte.
- R8: The temperature word is captured when a matching read address is accepted, so both bytes of one read come from the same sample even if `temp_in` changes between them.
- R9: A host ACK after a read byte makes the target send the next byte. A host NACK leaves `sda_oe` low until the next start or stop.
- R10: `rd_strobe` is a single-cycle pulse, issued once for each accepted read address.
- R11: With configuration bit 0 (shutdown) set, registers can still be written and read.
- R12: `sda_oe` changes only while the synchronised SCL is low.
- R13: A repeated start after the pointer byte begins a new address phase and keeps the new pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| temp_in | input | 16 | Latest converted temperature word |
| sda_oe | output | 1 | Drives the data line low while high |
| rd_strobe | output | 1 | One-cycle pulse per accepted read address |
| cfg_q | output | 8 | Configuration byte (bit 0 = shutdown) |
| low_q | output | 16 | Low limit word |
| high_q | output | 16 | High limit word |
| crit_q | output | 16 | Critical limit word |

## Verification
The bench sets `DEV_ADDR` to 0x48 and gives the three limits distinct reset words (0x0640, 0x2000, 0x3C00). With these values it can check the reset state of each limit separately and catch any mix-up between limit registers. A host using 0x49, which differs only in the lowest address bit, checks that address matching compares every bit. The synchroniser depth stays at two, and each SCL half period lasts twelve system clocks, so the bench runs at the oversampling margin the block is designed for.

// File: rtl/tsense_i2c_pkg.sv
package tsense_i2c_pkg;
  localparam int PTR_W   = 3;
  localparam int WORD_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int NUM_LIM = 3;

  localparam logic [PTR_W-1:0] SEL_TEMP = 3'd0;
  localparam logic [PTR_W-1:0] SEL_CFG  = 3'd1;
  localparam logic [PTR_W-1:0] SEL_LOW  = 3'd2;
  localparam logic [PTR_W-1:0] SEL_HIGH = 3'd3;
  localparam logic [PTR_W-1:0] SEL_CRIT = 3'd4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_PTR, ST_PTR_ACK,
    ST_WDAT, ST_WDAT_ACK, ST_RDAT, ST_RACK, ST_SKIP
  } bus_state_t;
endpackage

// File: rtl/tsense_line_sync.sv
module tsense_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_in};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_in};
      scl_p  <= scl_ff[SYNC_STAGES-1];
      sda_p  <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_ff[SYNC_STAGES-1];
  assign sda_s     = sda_ff[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/tsense_regs.sv
module tsense_regs
  import tsense_i2c_pkg::*;
#(
  parameter logic [WORD_W-1:0] LOW_RST  = 16'h0A00,
  parameter logic [WORD_W-1:0] HIGH_RST = 16'h4000,
  parameter logic [WORD_W-1:0] CRIT_RST = 16'h5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cfg,
  input  logic [BYTE_W-1:0] wr_cfg_data,
  input  logic              wr_lim,
  input  logic [PTR_W-1:0]  wr_lim_sel,
  input  logic [WORD_W-1:0] wr_lim_data,
  input  logic              snap_en,
  input  logic [WORD_W-1:0] temp_in,
  input  logic [PTR_W-1:0]  rd_sel,
  input  logic              rd_lsb,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [BYTE_W-1:0] cfg_q,
  output logic [WORD_W-1:0] lim_out [NUM_LIM]
);
  localparam logic [NUM_LIM-1:0][WORD_W-1:0] LIM_RST = {CRIT_RST, HIGH_RST, LOW_RST};

  logic [WORD_W-1:0] snap_q;
  logic [WORD_W-1:0] lim_q [NUM_LIM];
  logic [WORD_W-1:0] word_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      snap_q <= '0;
    end else begin
      if (wr_cfg)  cfg_q  <= wr_cfg_data;
      if (snap_en) snap_q <= temp_in;
    end
  end

  for (genvar g = 0; g < NUM_LIM; g++) begin : g_lim
    localparam logic [PTR_W-1:0] MY_SEL = SEL_LOW + (PTR_W)'(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             lim_q[g] <= LIM_RST[g];
      else if (wr_lim && wr_lim_sel == MY_SEL) lim_q[g] <= wr_lim_data;
    end
    assign lim_out[g] = lim_q[g];
  end

  always_comb begin
    word_sel = '0;
    case (rd_sel)
      SEL_TEMP: word_sel = snap_q;
      SEL_LOW:  word_sel = lim_q[0];
      SEL_HIGH: word_sel = lim_q[1];
      SEL_CRIT: word_sel = lim_q[2];
      default:  word_sel = '0;
    endcase
    if (rd_sel == SEL_CFG) rd_byte = cfg_q;
    else                   rd_byte = rd_lsb ? word_sel[BYTE_W-1:0] : word_sel[WORD_W-1:BYTE_W];
  end
endmodule

// File: rtl/tsense_bus_fsm.sv
module tsense_bus_fsm
  import tsense_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h4B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              sda_oe,
  output logic              rd_strobe,
  output logic [PTR_W-1:0]  ptr_q,
  output logic              rd_lsb,
  output logic              wr_cfg,
  output logic [BYTE_W-1:0] wr_cfg_data,
  output logic              wr_lim,
  output logic [WORD_W-1:0] wr_lim_data,
  output logic              snap_en
);
  bus_state_t        state;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] sr, tx, stage;
  logic [1:0]        widx;
  logic              rw, ack_bit;
  logic              byte_done, addr_hit, lim_ptr;

  assign byte_done   = scl_fall && (cnt == 4'd8);
  assign addr_hit    = (sr[7:1] == DEV_ADDR);
  assign lim_ptr     = (ptr_q == SEL_LOW) || (ptr_q == SEL_HIGH) || (ptr_q == SEL_CRIT);
  assign snap_en     = (state == ST_ADDR) && byte_done && addr_hit && sr[0];
  assign wr_cfg      = (state == ST_WDAT) && byte_done && (ptr_q == SEL_CFG) && (widx == 2'd0);
  assign wr_lim      = (state == ST_WDAT) && byte_done && lim_ptr && (widx == 2'd1);
  assign wr_cfg_data = sr;
  assign wr_lim_data = {stage, sr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      sr        <= '0;
      tx        <= '0;
      stage     <= '0;
      widx      <= '0;
      rw        <= 1'b0;
      ack_bit   <= 1'b1;
      ptr_q     <= SEL_TEMP;
      rd_lsb    <= 1'b0;
      sda_oe    <= 1'b0;
      rd_strobe <= 1'b0;
    end else begin
      rd_strobe <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_PTR, ST_WDAT: begin
            if (scl_rise && cnt < 4'd8) begin
              sr  <= {sr[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (byte_done) begin
              cnt <= '0;
              if (state == ST_ADDR) begin
                if (addr_hit) begin
                  state     <= ST_ADDR_ACK;
                  sda_oe    <= 1'b1;
                  rw        <= sr[0];
                  rd_strobe <= sr[0];
                  rd_lsb    <= 1'b0;
                end else begin
                  state <= ST_SKIP;
                end
              end else if (state == ST_PTR) begin
                ptr_q  <= sr[PTR_W-1:0];
                widx   <= '0;
                state  <= ST_PTR_ACK;
                sda_oe <= 1'b1;
              end else begin
                if (widx == 2'd0) stage <= sr;
                if (widx != 2'd2) widx <= widx + 2'd1;
                state  <= ST_WDAT_ACK;
                sda_oe <= 1'b1;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              state  <= ST_RDAT;
              tx     <= rd_byte;
              sda_oe <= ~rd_byte[7];
            end else begin
              state  <= ST_PTR;
              sda_oe <= 1'b0;
            end
          end
          ST_PTR_ACK, ST_WDAT_ACK: if (scl_fall) begin
            state  <= ST_WDAT;
            sda_oe <= 1'b0;
          end
          ST_RDAT: if (scl_fall) begin
            if (cnt == 4'd7) begin
              state  <= ST_RACK;
              sda_oe <= 1'b0;
              rd_lsb <= ~rd_lsb;
            end else begin
              tx     <= {tx[6:0], 1'b0};
              sda_oe <= ~tx[6];
              cnt    <= cnt + 4'd1;
            end
          end
          ST_RACK: begin
            if (scl_rise) ack_bit <= sda_s;
            else if (scl_fall) begin
              if (!ack_bit) begin
                state  <= ST_RDAT;
                tx     <= rd_byte;
                sda_oe <= ~rd_byte[7];
                cnt    <= '0;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tsense_i2c_target.sv
module tsense_i2c_target
  import tsense_i2c_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR    = 7'h4B,
  parameter int                SYNC_STAGES = 2,
  parameter logic [WORD_W-1:0] LOW_RST     = 16'h0A00,
  parameter logic [WORD_W-1:0] HIGH_RST    = 16'h4000,
  parameter logic [WORD_W-1:0] CRIT_RST    = 16'h5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [WORD_W-1:0] temp_in,
  output logic              sda_oe,
  output logic              rd_strobe,
  output logic [BYTE_W-1:0] cfg_q,
  output logic [WORD_W-1:0] low_q,
  output logic [WORD_W-1:0] high_q,
  output logic [WORD_W-1:0] crit_q
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [BYTE_W-1:0] rd_byte, wr_cfg_data;
  logic [PTR_W-1:0]  ptr_q;
  logic              rd_lsb, wr_cfg, wr_lim, snap_en;
  logic [WORD_W-1:0] wr_lim_data;
  logic [WORD_W-1:0] lim_out [NUM_LIM];

  tsense_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  tsense_bus_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_byte(rd_byte), .sda_oe(sda_oe), .rd_strobe(rd_strobe),
    .ptr_q(ptr_q), .rd_lsb(rd_lsb), .wr_cfg(wr_cfg),
    .wr_cfg_data(wr_cfg_data), .wr_lim(wr_lim), .wr_lim_data(wr_lim_data),
    .snap_en(snap_en)
  );

  tsense_regs #(.LOW_RST(LOW_RST), .HIGH_RST(HIGH_RST), .CRIT_RST(CRIT_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_cfg(wr_cfg), .wr_cfg_data(wr_cfg_data),
    .wr_lim(wr_lim), .wr_lim_sel(ptr_q), .wr_lim_data(wr_lim_data),
    .snap_en(snap_en), .temp_in(temp_in), .rd_sel(ptr_q), .rd_lsb(rd_lsb),
    .rd_byte(rd_byte), .cfg_q(cfg_q), .lim_out(lim_out)
  );

  assign low_q  = lim_out[0];
  assign high_q = lim_out[1];
  assign crit_q = lim_out[2];
endmodule

// File: rtl/tsense_i2c_target_chk.sv
module tsense_i2c_target_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_s,
  input logic        sda_oe,
  input logic        rd_strobe,
  input logic [7:0]  cfg_q,
  input logic [15:0] low_q,
  input logic [15:0] high_q,
  input logic [15:0] crit_q
);
  a_r10_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> !rd_strobe);

  a_r4_cfg_moves_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> sda_oe);

  a_r5_limits_move_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(low_q) || !$stable(high_q) || !$stable(crit_q)) |-> sda_oe);

  a_r12_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);
endmodule

bind tsense_i2c_target tsense_i2c_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .rd_strobe(rd_strobe), .cfg_q(cfg_q), .low_q(low_q),
  .high_q(high_q), .crit_q(crit_q)
);

// File: tb/tb_tsense_i2c_target.sv
module tb_tsense_i2c_target;
  localparam int CLK_PERIOD = 10;
  localparam int HB = 12;
  localparam logic [6:0]  ADDR = 7'h48;
  localparam logic [15:0] LOW0 = 16'h0640, HIGH0 = 16'h2000, CRIT0 = 16'h3C00;

  logic clk = 0, rst_n = 0, scl = 1, host_sda = 1;
  logic [15:0] temp_in = 16'h0;
  logic sda_oe, rd_strobe;
  logic [7:0] cfg_q;
  logic [15:0] low_q, high_q, crit_q;
  logic sda_line;
  assign sda_line = host_sda & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsense_i2c_target #(.DEV_ADDR(ADDR), .LOW_RST(LOW0), .HIGH_RST(HIGH0), .CRIT_RST(CRIT0)) dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line), .temp_in(temp_in),
    .sda_oe(sda_oe), .rd_strobe(rd_strobe), .cfg_q(cfg_q), .low_q(low_q),
    .high_q(high_q), .crit_q(crit_q)
  );

  int total = 0, bad = 0;
  bit compare_en = 0, done = 0;
  logic [7:0]  m_cfg = 8'h00, m_stage = 8'h00;
  logic [15:0] m_low = LOW0, m_high = HIGH0, m_crit = CRIT0;
  logic [2:0]  m_ptr = 3'd0;
  int m_strobes = 0, strobe_cnt = 0;
  logic prev_oe = 0;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison of the register outputs against the model
  always @(posedge clk) begin
    if (rst_n && compare_en) begin
      check("R4 cfg", cfg_q, m_cfg);
      check("R5 low", low_q, m_low);
      check("R5 high", high_q, m_high);
      check("R5 crit", crit_q, m_crit);
    end
    if (rst_n && rd_strobe) strobe_cnt++;
    if (rst_n && sda_oe !== prev_oe) check("R12 sda change while scl high", scl, 0);
    prev_oe = sda_oe;
  end

  task automatic hw(input int n); repeat (n) @(negedge clk); endtask
  task automatic settle(); hw(2); compare_en = 1; endtask

  task automatic bus_start();
    host_sda = 1; hw(HB); scl = 1; hw(HB); host_sda = 0; hw(HB); scl = 0; hw(HB);
  endtask
  task automatic bus_stop();
    host_sda = 0; hw(HB); scl = 1; hw(HB); host_sda = 1; hw(HB);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      host_sda = b[i]; hw(HB); scl = 1; hw(HB);
      if (i == 0) compare_en = 0;
      scl = 0;
    end
    host_sda = 1; hw(HB); scl = 1; hw(HB/2); acked = !sda_line; hw(HB/2); scl = 0;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic nack);
    for (int i = 7; i >= 0; i--) begin
      hw(HB); scl = 1; hw(HB/2); b[i] = sda_line; hw(HB/2); scl = 0;
    end
    host_sda = nack; hw(HB); scl = 1; hw(HB); scl = 0; host_sda = 1;
  endtask

  function automatic logic [7:0] exp_byte(input logic [2:0] p, input int k, input logic [15:0] snap);
    logic [15:0] w;
    case (p)
      3'd0: w = snap;
      3'd2: w = m_low;
      3'd3: w = m_high;
      3'd4: w = m_crit;
      default: w = 16'h0;
    endcase
    if (p == 3'd1) return m_cfg;
    return (k % 2 == 0) ? w[15:8] : w[7:0];
  endfunction

  task automatic model_write(input int k, input logic [7:0] b);
    case (m_ptr)
      3'd1: if (k == 0) m_cfg = b;
      3'd2, 3'd3, 3'd4: begin
        if (k == 0) m_stage = b;
        else if (k == 1) begin
          if (m_ptr == 3'd2) m_low = {m_stage, b};
          else if (m_ptr == 3'd3) m_high = {m_stage, b};
          else m_crit = {m_stage, b};
        end
      end
      default: ;
    endcase
  endtask

  task automatic wr_txn(input logic [6:0] a, input logic [7:0] p, input int n,
                        input logic [23:0] d, input string tag);
    logic ak;
    logic match;
    match = (a == ADDR);
    bus_start();
    send_byte({a, 1'b0}, ak); settle(); check({tag, " addr ack"}, ak, match);
    send_byte(p, ak);
    if (match) m_ptr = p[2:0];
    settle(); check({tag, " ptr ack"}, ak, match);
    for (int k = 0; k < n; k++) begin
      logic [7:0] b;
      b = d[23-8*k -: 8];
      send_byte(b, ak);
      if (match) model_write(k, b);
      settle(); check({tag, " data ack"}, ak, match);
    end
    bus_stop();
  endtask

  task automatic rd_txn(input bit set_ptr, input logic [7:0] p, input int n,
                        input logic [15:0] t_mid, input string tag);
    logic ak;
    logic [7:0] b;
    logic [15:0] snap;
    bus_start();
    if (set_ptr) begin
      send_byte({ADDR, 1'b0}, ak); settle();
      send_byte(p, ak); m_ptr = p[2:0]; settle();
      bus_start();
    end
    send_byte({ADDR, 1'b1}, ak); snap = temp_in; m_strobes++;
    check({tag, " read addr ack"}, ak, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(b, (k == n-1));
      check({tag, " read byte"}, b, exp_byte(m_ptr, k, snap));
      if (k == 0) temp_in = t_mid;
    end
    hw(4);
    check("R9 released after NACK", sda_oe, 0);
    bus_stop();
    settle();
    check("R10 strobe count", strobe_cnt, m_strobes);
  endtask

  initial begin
    hw(5); rst_n = 1; hw(3);
    check("R1 cfg", cfg_q, 8'h00);
    check("R1 low", low_q, LOW0);
    check("R1 high", high_q, HIGH0);
    check("R1 crit", crit_q, CRIT0);
    check("R1 sda_oe", sda_oe, 0);
    check("R1 rd_strobe", rd_strobe, 0);
    compare_en = 1;

    temp_in = 16'h1234;
    rd_txn(0, 8'h00, 2, 16'h1234, "R1 R7 default pointer");
    wr_txn(ADDR, 8'h01, 2, 24'h5AFF00, "R4 cfg extra byte");
    wr_txn(ADDR, 8'h02, 2, 24'h128000, "R5 low two bytes");
    wr_txn(ADDR, 8'h03, 1, 24'h770000, "R5 high single byte");
    wr_txn(ADDR, 8'h04, 3, 24'hABCDEF, "R5 crit three bytes");
    wr_txn(ADDR, 8'h00, 2, 24'h999900, "R6 temp write");
    temp_in = 16'h2468;
    rd_txn(1, 8'h00, 2, 16'h2468, "R6 temp read");
    rd_txn(1, 8'h02, 4, m_low, "R7 R13 low repeated");
    rd_txn(0, 8'h00, 2, temp_in, "R3 latched pointer");
    rd_txn(1, 8'h01, 3, temp_in, "R7 cfg repeats");
    rd_txn(1, 8'h04, 2, temp_in, "R3 crit read");
    wr_txn(7'h49, 8'h03, 2, 24'h112200, "R2 wrong address");
    rd_txn(0, 8'h00, 2, temp_in, "R2 pointer kept");
    temp_in = 16'hA5C3;
    rd_txn(1, 8'h00, 2, 16'h0F0F, "R8 snapshot");
    wr_txn(ADDR, 8'h06, 2, 24'h334400, "R3 unmapped write");
    rd_txn(0, 8'h00, 2, temp_in, "R3 unmapped read");
    wr_txn(ADDR, 8'hF9, 1, 24'h010000, "R3 upper bits ignored R11 shutdown set");
    wr_txn(ADDR, 8'h03, 2, 24'h445500, "R11 write in shutdown");
    rd_txn(0, 8'h00, 2, temp_in, "R11 read in shutdown");
    rd_txn(1, 8'h01, 1, temp_in, "R11 cfg readback");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule